// File: doc/BRIEF.md
# Pulse-Swallow Programmable RF Divider

This block divides a fast RF-side clock by a programmable ratio N = 16·M + A, where M is a 13-bit main count and A is a 4-bit swallow count. Inside, a 16/17 dual-modulus prescaler is modelled in logic. The swallow counter holds the prescaler at modulus 17 for the first A prescaler cycles of every division cycle, and at modulus 16 for the M − A cycles that follow. An optional halving stage can be placed ahead of the prescaler, which doubles every ratio. It is selected by a static control bit.

The divider emits one single-clock pulse per completed division cycle, and that pulse feeds the phase comparator. One cycle earlier it raises a boundary flag. The control side uses this flag to know when its ratio inputs are taken, because the ratio inputs are sampled only at that boundary. A ratio below the smallest legal value is replaced by the smallest legal value.

There is no streaming data path, so the block has no valid/ready handshake and applies no back-pressure. Every pin is a plain control or status level or pulse. The output pulse cannot be stalled, and the ratio inputs are simply levels that must be settled when the boundary flag is high.

Top module: `psw_divider`

## Requirements
- R1: With `half_en` low, consecutive `div_pulse` assertions are exactly 16·M + A clock cycles apart for any legal ratio from 240 to 131071.
- R2: With `half_en` high, the spacing is exactly 2·(16·M + A) clock cycles, from 480 to 262142. `half_en` is changed only while `rst_n` is low and is held stable otherwise.
- R3: `ratio_m`/`ratio_a` are sampled only at the clock edge that ends a cycle in which `ratio_take` is high. A change at any other time leaves the division cycle in progress unchanged.
- R4: A sampled ratio 16·M + A below 240, which includes every case with M < A, is treated as M = 15, A = 0 (240, or 480 with halving). No two `ratio_take` assertions are ever closer than 240 cycles.
- R5: `div_pulse` is high for exactly one clock cycle per division cycle.
- R6: `ratio_take` is high for exactly one cycle per division cycle, in the cycle immediately before `div_pulse`. With halving enabled it is never high in two consecutive cycles.
- R7: While `rst_n` is low, both outputs are low. After release, the first ratio is taken on the second clock edge without any pulse. With halving off, the first `div_pulse` then appears N cycles later, which is 242 cycles after release for N = 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF-side clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| half_en | input | 1 | Static select for the divide-by-two stage ahead of the prescaler |
| ratio_m | input | 13 | Main count M |
| ratio_a | input | 4 | Swallow count A |
| ratio_take | output | 1 | High in the cycle whose closing edge samples the ratio inputs |
| div_pulse | output | 1 | One-cycle pulse marking each completed division cycle |

## Verification
Ratios with A = 0 and A = 15 at the same M separate the swallow modulus from the plain modulus. A ratio one step above the minimum (M = 16, A = 1) and a mid-range ratio catch an off-by-one in either counter. The largest ratio exercises the full width of the main counter. Ratios just below the minimum, including ones with M < A, show whether clamping happens, and the same ratios with halving on show that the halving applies to the clamped value too. A ratio change in the middle of a division cycle shows whether the boundary-only sampling holds, and the count from reset release pins down the startup load.

// File: rtl/psw_pkg.sv
package psw_pkg;
  // Default geometry of the divider.
  localparam int unsigned MAIN_W    = 13;
  localparam int unsigned SWALLOW_W = 4;
  localparam int unsigned LEGAL_MIN = 240;
endpackage

// File: rtl/psw_front.sv
// Optional halving stage: produces the count-enable for the prescaler.
module psw_front (
  input  logic clk,
  input  logic rst_n,
  input  logic half_en,
  output logic tick
);
  logic run;
  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      phase <= 1'b0;
    end else begin
      run   <= 1'b1;
      phase <= half_en & run & ~phase;
    end
  end

  always_comb tick = run & (~half_en | phase);
endmodule

// File: rtl/psw_ratio_gate.sv
// Replaces any ratio below the legal minimum with the minimum itself.
module psw_ratio_gate #(
  parameter int unsigned M_W       = 13,
  parameter int unsigned A_W       = 4,
  parameter int unsigned MIN_RATIO = 240
) (
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  output logic [M_W-1:0] m_ok,
  output logic [A_W-1:0] a_ok
);
  localparam int unsigned N_W = M_W + A_W;
  localparam logic [N_W-1:0] MIN_N = N_W'(MIN_RATIO);

  logic [N_W-1:0] n_in;

  always_comb begin
    n_in = {m_in, a_in};
    if (n_in < MIN_N) {m_ok, a_ok} = MIN_N;
    else              {m_ok, a_ok} = n_in;
  end
endmodule

// File: rtl/psw_core.sv
// Dual-modulus prescaler plus main and swallow counters.
module psw_core #(
  parameter int unsigned M_W = 13,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [M_W-1:0] ld_m,
  input  logic [A_W-1:0] ld_a,
  output logic           term,
  output logic           pulse
);
  localparam int unsigned P_W = A_W + 1;
  localparam logic [P_W-1:0] LAST_LONG  = {1'b1, {A_W{1'b0}}};
  localparam logic [P_W-1:0] LAST_SHORT = {1'b0, {A_W{1'b1}}};
  localparam logic [M_W-1:0] M_ONE      = M_W'(1);

  logic [P_W-1:0] pcnt;
  logic [M_W-1:0] mcnt;
  logic [A_W-1:0] acnt;
  logic [A_W-1:0] acnt_nx;
  logic           pre_end;
  logic           primed;

  always_comb begin
    pre_end = tick && (pcnt == '0);
    term    = pre_end && (mcnt == M_ONE);
    acnt_nx = (acnt != '0) ? acnt - A_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt   <= '0;
      mcnt   <= M_ONE;
      acnt   <= '0;
      primed <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      pulse <= term & primed;
      if (term) begin
        mcnt   <= ld_m;
        acnt   <= ld_a;
        pcnt   <= (ld_a != '0) ? LAST_LONG : LAST_SHORT;
        primed <= 1'b1;
      end else if (pre_end) begin
        mcnt <= mcnt - M_W'(1);
        acnt <= acnt_nx;
        pcnt <= (acnt_nx != '0) ? LAST_LONG : LAST_SHORT;
      end else if (tick) begin
        pcnt <= pcnt - P_W'(1);
      end
    end
  end
endmodule

// File: rtl/psw_divider.sv
module psw_divider #(
  parameter int unsigned M_W       = psw_pkg::MAIN_W,
  parameter int unsigned A_W       = psw_pkg::SWALLOW_W,
  parameter int unsigned MIN_RATIO = psw_pkg::LEGAL_MIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           half_en,
  input  logic [M_W-1:0] ratio_m,
  input  logic [A_W-1:0] ratio_a,
  output logic           ratio_take,
  output logic           div_pulse
);
  logic           tick;
  logic [M_W-1:0] m_ok;
  logic [A_W-1:0] a_ok;

  psw_front u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .half_en (half_en),
    .tick    (tick)
  );

  psw_ratio_gate #(.M_W(M_W), .A_W(A_W), .MIN_RATIO(MIN_RATIO)) u_gate (
    .m_in (ratio_m),
    .a_in (ratio_a),
    .m_ok (m_ok),
    .a_ok (a_ok)
  );

  psw_core #(.M_W(M_W), .A_W(A_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .ld_m  (m_ok),
    .ld_a  (a_ok),
    .term  (ratio_take),
    .pulse (div_pulse)
  );
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
  parameter int unsigned MIN_RATIO = 240
) (
  input logic clk,
  input logic rst_n,
  input logic half_en,
  input logic ratio_take,
  input logic div_pulse
);
  localparam int unsigned GW = $clog2(MIN_RATIO) + 1;
  localparam logic [GW-1:0] GAP_MIN = GW'(MIN_RATIO - 1);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (ratio_take) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != GAP_MIN) begin
      gap <= gap + GW'(1);
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R5
  AST_PULSE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(ratio_take)); // R6
  AST_TAKE_SPACED_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && ratio_take) |=> !ratio_take); // R6
  AST_TAKE_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_take && seen) |-> (gap == GAP_MIN)); // R4
  AST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(half_en)); // R2
endmodule

bind psw_divider psw_divider_chk #(.MIN_RATIO(MIN_RATIO)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .half_en    (half_en),
  .ratio_take (ratio_take),
  .div_pulse  (div_pulse)
);

// File: tb/psw_divider_test.sv
module psw_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        half_en = 1'b0;
  logic [12:0] ratio_m = 13'd15;
  logic [3:0]  ratio_a = 4'd0;
  logic        ratio_take;
  logic        div_pulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  psw_divider uut (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .ratio_m(ratio_m), .ratio_a(ratio_a),
    .ratio_take(ratio_take), .div_pulse(div_pulse)
  );

  // {half, M, A, expected spacing}
  localparam int NV = 10;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 13'd15,   4'd0,  19'd240},
    {1'b0, 13'd15,   4'd15, 19'd255},
    {1'b0, 13'd16,   4'd1,  19'd257},
    {1'b0, 13'd20,   4'd7,  19'd327},
    {1'b0, 13'd14,   4'd15, 19'd240},
    {1'b0, 13'd3,    4'd9,  19'd240},
    {1'b0, 13'd8191, 4'd15, 19'd131071},
    {1'b1, 13'd15,   4'd0,  19'd480},
    {1'b1, 13'd100,  4'd5,  19'd3210},
    {1'b1, 13'd14,   4'd2,  19'd480}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !wd_hit) begin
      wd_hit = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic half);
    @(negedge clk);
    rst_n = 1'b0;
    half_en = half;
    repeat (3) @(negedge clk);
    check(!div_pulse && !ratio_take, "R7 outputs low in reset",
          {ratio_take, div_pulse}, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse && !wd_hit);
  endtask

  // Called just after a pulse was sampled; counts cycles to the next one.
  task automatic measure(output int n, output int takes, output bit take_before,
                         output bit low_after);
    bit prev;
    n = 0; takes = 0; take_before = 1'b0; low_after = 1'b0; prev = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) low_after = !div_pulse;
      if (div_pulse) take_before = prev;
      if (ratio_take) takes++;
      prev = ratio_take;
    end while (!div_pulse && !wd_hit);
  endtask

  initial begin
    int n, takes;
    bit tb4, low;

    // R7: reset state and startup load timing
    ratio_m = 13'd15; ratio_a = 4'd0;
    do_reset(1'b0);
    n = 0; takes = 0;
    do begin
      @(negedge clk);
      n++;
      if (ratio_take) takes++;
    end while (!div_pulse && !wd_hit);
    check(n == 242, "R7 first pulse after release", n, 242);
    check(takes == 2, "R7 takes before first pulse", takes, 2);

    // R3: change mid-cycle, current cycle keeps old ratio
    n = 0;
    repeat (50) begin @(negedge clk); n++; end
    ratio_m = 13'd18; ratio_a = 4'd12;
    do begin @(negedge clk); n++; end while (!div_pulse && !wd_hit);
    check(n == 240, "R3 cycle in progress unchanged", n, 240);
    measure(n, takes, tb4, low);
    check(n == 300, "R3 new ratio after boundary", n, 300);

    // Table walk: R1, R2, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      logic        h;
      logic [12:0] m;
      logic [3:0]  a;
      int          exp;
      string       req;
      {h, m, a} = VEC[i][36:19];
      exp = int'(VEC[i][18:0]);
      req = (int'({m, a}) < 240) ? "R4" : (h ? "R2" : "R1");
      if (h != half_en) begin
        ratio_m = m; ratio_a = a;
        do_reset(h);
      end else begin
        ratio_m = m; ratio_a = a;
      end
      wait_pulse();
      measure(n, takes, tb4, low);
      check(n == exp, req, n, exp);
      check(low, "R5 pulse one cycle wide", 0, 1);
      check(takes == 1 && tb4, "R6 single take before pulse", takes, 1);
    end

    summary();
  end
endmodule